// File: doc/BRIEF.md
# Privileged Control Register File

This block holds the privileged control and status state of one processor strand. Access goes through a single port that takes a register number. The port carries an access strobe, a write enable, and 64-bit write data. It returns 64-bit read data and an error flag one cycle later.

Most registers keep exactly what is written to them. Some registers behave differently:
- The processor-state register drops bits on write.
- The trap-base register drops bits on write.
- The floating-point state register reads back with its two low bits set.
- Five trap-context registers are banked, one copy per trap level.

A read-only context word gathers fields from several registers for a translation unit nearby. Writing the trap level can raise a trap-level-zero interrupt request. That request holds until the next trap-level write.

Top module: `priv_ctl_regs`

## Requirements
- R1: After reset, the hyper-state register (index 3) reads 0x800 and the strand status register (index 4) reads 0x50000. Every other register reads zero, except index 5 (see R6). errFlag and tlzIrq are low after reset.
- R2: A write to the processor-state register (index 0) keeps only bits 12, 9:6 and 4:1 (mask 0x13DE) and stores zero in all other bits.
- R3: A write to the trap-base register (index 1) stores the data with bits 14:0 cleared.
- R4: The trap level is a 3-bit register at index 2. Indices 16 to 20 are banked registers: trap PC, trap next-PC, trap state, trap type and hyper trap state. Each access to them uses the copy for level (trap level − 1).
- R5: An access to a banked register while the trap level is 0 or above MAX_TL is flagged as an error. It reads zero and changes no state.
- R6: A read of the floating-point state register (index 5) returns the stored value with bits 1:0 forced to 1.
- R7: Index 10 reads the context word, built from these fields:
  - bit 0 is hyper-state bit 2, and bit 1 is hyper-state bit 5;
  - bits 3:2 are processor-state bits 3:2;
  - bits 5:4 are load-store control (index 9) bits 3:2;
  - bits 15:8 are partition ID (index 6) bits 7:0;
  - bits 18:16 are the trap level;
  - bits 47:32 are primary context (index 7) bits 15:0;
  - bits 63:48 are secondary context (index 8) bits 15:0.
  
  A write to index 10 is flagged as an error.
- R8: The implemented indices are 0–10, 16–20, 24–31 and 32–39. An access to any other index raises errFlag for one cycle, reads zero, and changes no state.
- R9: Scratchpad registers (indices 24–31) and queue pointers (indices 32–39) store and return the full 64-bit value written.
- R10: A trap-level write sets tlzIrq when three conditions hold: hyper-state bit 0 (TLZ enable) is 1, the new level is 0, and hyper-state bit 2 (hyper-privileged) is 0. Any other trap-level write clears tlzIrq. Other accesses leave tlzIrq unchanged.
- R11: rdData and errFlag are registered and take their value in the cycle after an access. A write access returns zero on rdData.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accEn | input | 1 | Access strobe for one cycle |
| wrEn | input | 1 | The access is a write when set |
| regIdx | input | 6 | Register number |
| wrData | input | 64 | Write data |
| rdData | output | 64 | Read result, valid the cycle after a read |
| errFlag | output | 1 | One-cycle pulse for a refused access |
| tlzIrq | output | 1 | Trap-level-zero interrupt request |

## Verification
The bench builds the block with MAX_TL set to 4 instead of the default 6. This lets the 3-bit trap level be set to 5, one step past the deepest bank, so the upper-bound refusal in R5 can be tested next to the zero-level refusal. With four levels, the bench also writes and reads back the top bank slot, and it shows that a refused write there leaves the stored value intact. Scratchpad and queue counts stay at 8, which fills every implemented index so that the neighbouring gaps can be probed.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int DW    = 64;
  localparam int IDX_W = 6;
  localparam int TL_W  = 3;

  localparam logic [IDX_W-1:0] IDX_PS   = 6'd0;
  localparam logic [IDX_W-1:0] IDX_TBA  = 6'd1;
  localparam logic [IDX_W-1:0] IDX_TL   = 6'd2;
  localparam logic [IDX_W-1:0] IDX_HS   = 6'd3;
  localparam logic [IDX_W-1:0] IDX_SS   = 6'd4;
  localparam logic [IDX_W-1:0] IDX_FP   = 6'd5;
  localparam logic [IDX_W-1:0] IDX_PID  = 6'd6;
  localparam logic [IDX_W-1:0] IDX_PRI  = 6'd7;
  localparam logic [IDX_W-1:0] IDX_SEC  = 6'd8;
  localparam logic [IDX_W-1:0] IDX_LSU  = 6'd9;
  localparam logic [IDX_W-1:0] IDX_CTX  = 6'd10;

  localparam int BANK_BASE = 16;
  localparam int N_BANK    = 5;
  localparam int SCR_BASE  = 24;
  localparam int QUE_BASE  = 32;

  localparam logic [DW-1:0] PS_KEEP  = 64'h0000_0000_0000_13DE;
  localparam logic [DW-1:0] TBA_KEEP = ~64'h0000_0000_0000_7FFF;
  localparam logic [DW-1:0] HS_RESET = 64'h0000_0000_0000_0800;
  localparam logic [DW-1:0] SS_RESET = 64'h0000_0000_0005_0000;
  localparam int HS_TLZ   = 0;
  localparam int HS_HPRIV = 2;
  localparam int HS_RED   = 5;

  typedef enum logic [3:0] {
    K_PS, K_TBA, K_TL, K_HS, K_SS, K_FP, K_PID, K_PRI, K_SEC, K_LSU,
    K_CTX, K_BANK, K_SCR, K_QUE, K_BAD
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [2:0] sub;
    logic       acc;
    logic       wr;
    logic       rd;
    logic       fault;
  } strobe_t;
endpackage

// File: rtl/pcr_decode.sv
module pcr_decode
  import pcr_pkg::*;
#(
  parameter int MAX_TL = 6,
  parameter int N_SCR  = 8,
  parameter int N_QUE  = 8
) (
  input  logic             accEn,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] regIdx,
  input  logic [TL_W-1:0]  curTl,
  output strobe_t          stb
);
  localparam int BANK_END = BANK_BASE + N_BANK;
  localparam int SCR_END  = SCR_BASE + N_SCR;
  localparam int QUE_END  = QUE_BASE + N_QUE;

  int   idxI;
  int   offI;
  logic bankOk;

  always_comb begin
    idxI   = int'(regIdx);
    offI   = 0;
    bankOk = (curTl != '0) && (int'(curTl) <= MAX_TL);
    stb.kind = K_BAD;
    case (regIdx)
      IDX_PS:  stb.kind = K_PS;
      IDX_TBA: stb.kind = K_TBA;
      IDX_TL:  stb.kind = K_TL;
      IDX_HS:  stb.kind = K_HS;
      IDX_SS:  stb.kind = K_SS;
      IDX_FP:  stb.kind = K_FP;
      IDX_PID: stb.kind = K_PID;
      IDX_PRI: stb.kind = K_PRI;
      IDX_SEC: stb.kind = K_SEC;
      IDX_LSU: stb.kind = K_LSU;
      IDX_CTX: stb.kind = K_CTX;
      default: begin
        if (idxI >= BANK_BASE && idxI < BANK_END) begin
          stb.kind = K_BANK; offI = idxI - BANK_BASE;
        end else if (idxI >= SCR_BASE && idxI < SCR_END) begin
          stb.kind = K_SCR;  offI = idxI - SCR_BASE;
        end else if (idxI >= QUE_BASE && idxI < QUE_END) begin
          stb.kind = K_QUE;  offI = idxI - QUE_BASE;
        end
      end
    endcase
    stb.sub   = offI[2:0];
    stb.acc   = accEn;
    stb.fault = accEn && ((stb.kind == K_BAD) ||
                          (stb.kind == K_BANK && !bankOk) ||
                          (stb.kind == K_CTX && wrEn));
    stb.wr    = accEn && wrEn && !stb.fault;
    stb.rd    = accEn && !wrEn && !stb.fault;
  end
endmodule

// File: rtl/pcr_store.sv
module pcr_store
  import pcr_pkg::*;
#(
  parameter int MAX_TL = 6,
  parameter int N_SCR  = 8,
  parameter int N_QUE  = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [DW-1:0]   wrData,
  output logic [TL_W-1:0] tlLevel,
  output logic [DW-1:0]   rdData,
  output logic            errFlag,
  output logic            tlzIrq
);
  localparam int SLOT_W = $clog2(MAX_TL);
  localparam int SCR_IW = $clog2(N_SCR);
  localparam int QUE_IW = $clog2(N_QUE);

  logic [DW-1:0] procState, trapBase, hyperState, strandSts, fpState;
  logic [DW-1:0] partId, priCtx, secCtx, lsuCtrl;
  logic [DW-1:0] bank [N_BANK][MAX_TL];
  logic [DW-1:0] scr  [N_SCR];
  logic [DW-1:0] que  [N_QUE];

  logic [SLOT_W-1:0] slot;
  logic [SCR_IW-1:0] scrSel;
  logic [QUE_IW-1:0] queSel;
  logic [DW-1:0]     ctxWord;
  logic [DW-1:0]     rdComb;

  assign slot   = SLOT_W'(tlLevel - TL_W'(1));
  assign scrSel = SCR_IW'(stb.sub);
  assign queSel = QUE_IW'(stb.sub);

  assign ctxWord = {secCtx[15:0], priCtx[15:0], 13'b0, tlLevel, partId[7:0],
                    2'b0, lsuCtrl[3:2], procState[3:2],
                    hyperState[HS_RED], hyperState[HS_HPRIV]};

  always_comb begin
    case (stb.kind)
      K_PS:    rdComb = procState;
      K_TBA:   rdComb = trapBase;
      K_TL:    rdComb = DW'(tlLevel);
      K_HS:    rdComb = hyperState;
      K_SS:    rdComb = strandSts;
      K_FP:    rdComb = fpState | 64'h3;
      K_PID:   rdComb = partId;
      K_PRI:   rdComb = priCtx;
      K_SEC:   rdComb = secCtx;
      K_LSU:   rdComb = lsuCtrl;
      K_CTX:   rdComb = ctxWord;
      K_BANK:  rdComb = bank[stb.sub][slot];
      K_SCR:   rdComb = scr[scrSel];
      K_QUE:   rdComb = que[queSel];
      default: rdComb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      procState <= '0; trapBase <= '0; hyperState <= HS_RESET;
      strandSts <= SS_RESET; fpState <= '0; partId <= '0;
      priCtx <= '0; secCtx <= '0; lsuCtrl <= '0; tlLevel <= '0;
      rdData <= '0; errFlag <= 1'b0; tlzIrq <= 1'b0;
      for (int b = 0; b < N_BANK; b++)
        for (int l = 0; l < MAX_TL; l++) bank[b][l] <= '0;
      for (int i = 0; i < N_SCR; i++) scr[i] <= '0;
      for (int i = 0; i < N_QUE; i++) que[i] <= '0;
    end else begin
      errFlag <= stb.fault;
      if (stb.acc) rdData <= stb.rd ? rdComb : '0;
      if (stb.wr) begin
        case (stb.kind)
          K_PS:   procState  <= wrData & PS_KEEP;
          K_TBA:  trapBase   <= wrData & TBA_KEEP;
          K_TL: begin
            tlLevel <= wrData[TL_W-1:0];
            tlzIrq  <= hyperState[HS_TLZ] && (wrData[TL_W-1:0] == '0) &&
                       !hyperState[HS_HPRIV];
          end
          K_HS:   hyperState <= wrData;
          K_SS:   strandSts  <= wrData;
          K_FP:   fpState    <= wrData;
          K_PID:  partId     <= wrData;
          K_PRI:  priCtx     <= wrData;
          K_SEC:  secCtx     <= wrData;
          K_LSU:  lsuCtrl    <= wrData;
          K_BANK: bank[stb.sub][slot] <= wrData;
          K_SCR:  scr[scrSel] <= wrData;
          K_QUE:  que[queSel] <= wrData;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/priv_ctl_regs.sv
module priv_ctl_regs
  import pcr_pkg::*;
#(
  parameter int MAX_TL = 6,
  parameter int N_SCR  = 8,
  parameter int N_QUE  = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          accEn,
  input  logic          wrEn,
  input  logic [5:0]    regIdx,
  input  logic [63:0]   wrData,
  output logic [63:0]   rdData,
  output logic          errFlag,
  output logic          tlzIrq
);
  strobe_t         stb;
  logic [TL_W-1:0] curTl;

  pcr_decode #(.MAX_TL(MAX_TL), .N_SCR(N_SCR), .N_QUE(N_QUE)) u_decode (
    .accEn(accEn), .wrEn(wrEn), .regIdx(regIdx), .curTl(curTl), .stb(stb)
  );

  pcr_store #(.MAX_TL(MAX_TL), .N_SCR(N_SCR), .N_QUE(N_QUE)) u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .tlLevel(curTl),
    .rdData(rdData), .errFlag(errFlag), .tlzIrq(tlzIrq)
  );
endmodule

// File: rtl/priv_ctl_regs_chk.sv
module priv_ctl_regs_chk
  import pcr_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        accEn,
  input logic        wrEn,
  input logic [5:0]  regIdx,
  input logic [63:0] rdData,
  input logic        errFlag,
  input logic        tlzIrq
);
  // R8
  err_needs_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> $past(accEn));
  // R8
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> rdData == '0);
  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(accEn && wrEn && regIdx == IDX_TL) |-> tlzIrq == $past(tlzIrq));
  // R6
  fp_low_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(accEn && !wrEn && regIdx == IDX_FP) |-> rdData[1:0] == 2'b11);
  // R2
  ps_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(accEn && !wrEn && regIdx == IDX_PS) |-> (rdData & ~PS_KEEP) == '0);
  // R3
  tba_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(accEn && !wrEn && regIdx == IDX_TBA) |-> rdData[14:0] == '0);
  // R7
  ctx_write_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(accEn && wrEn && regIdx == IDX_CTX) |-> errFlag);
endmodule

bind priv_ctl_regs priv_ctl_regs_chk u_chk (
  .clk(clk), .rstN(rstN), .accEn(accEn), .wrEn(wrEn), .regIdx(regIdx),
  .rdData(rdData), .errFlag(errFlag), .tlzIrq(tlzIrq)
);

// File: tb/priv_ctl_regs_tb.sv
module priv_ctl_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  regIdx = '0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;
  logic        errFlag;
  logic        tlzIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit modelIrq = 1'b0;

  logic [63:0] qRd[$];
  bit          qErr[$];
  bit          qIrq[$];
  string       qTag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  priv_ctl_regs #(.MAX_TL(4)) u_dut (
    .clk(clk), .rstN(rstN), .accEn(accEn), .wrEn(wrEn), .regIdx(regIdx),
    .wrData(wrData), .rdData(rdData), .errFlag(errFlag), .tlzIrq(tlzIrq)
  );

  task automatic acc(input logic [5:0] idx, input bit we, input logic [63:0] d,
                     input logic [63:0] expRd, input bit expErr, input string tag);
    @(negedge clk);
    accEn = 1'b1; wrEn = we; regIdx = idx; wrData = d;
    qRd.push_back(expRd); qErr.push_back(expErr);
    qIrq.push_back(modelIrq); qTag.push_back(tag);
    @(negedge clk);
    accEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic wr(input logic [5:0] idx, input logic [63:0] d, input string tag);
    acc(idx, 1'b1, d, 64'h0, 1'b0, tag);
  endtask

  task automatic rd(input logic [5:0] idx, input logic [63:0] e, input string tag);
    acc(idx, 1'b0, 64'h0, e, 1'b0, tag);
  endtask

  task automatic bad(input logic [5:0] idx, input bit we, input string tag);
    acc(idx, we, '1, 64'h0, 1'b1, tag);
  endtask

  // monitor: compare each access result the cycle after it was issued
  initial begin
    forever begin
      @(posedge clk);
      if (accEn === 1'b1) begin
        logic [63:0] eRd;
        bit eErr;
        bit eIrq;
        string t;
        @(negedge clk);
        eRd = qRd.pop_front(); eErr = qErr.pop_front();
        eIrq = qIrq.pop_front(); t = qTag.pop_front();
        nChecks++;
        if (rdData !== eRd || errFlag !== eErr || tlzIrq !== eIrq) begin
          nFails++;
          $display("FAIL %s: rd=%h err=%b irq=%b expected rd=%h err=%b irq=%b",
                   t, rdData, errFlag, tlzIrq, eRd, eErr, eIrq);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    nChecks++;
    if (rdData !== 64'h0 || errFlag !== 1'b0 || tlzIrq !== 1'b0) begin
      nFails++;
      $display("FAIL R1 reset outputs: rd=%h err=%b irq=%b expected 0 0 0",
               rdData, errFlag, tlzIrq);
    end

    // R1 reset values
    rd(6'd3, 64'h800, "R1 hyper-state reset");
    rd(6'd4, 64'h50000, "R1 strand status reset");
    rd(6'd0, 64'h0, "R1 proc-state reset");
    rd(6'd2, 64'h0, "R1 trap level reset");
    rd(6'd24, 64'h0, "R1 scratch reset");

    // R6 / R11
    rd(6'd5, 64'h3, "R6 fp reset read");
    wr(6'd5, 64'h10, "R11 write returns zero");
    rd(6'd5, 64'h13, "R6 fp low bits forced");

    // R2
    wr(6'd0, '1, "R2 all ones");
    rd(6'd0, 64'h13DE, "R2 masked keep");
    wr(6'd0, ~64'h13DE, "R2 complement");
    rd(6'd0, 64'h0, "R2 complement dropped");

    // R3
    wr(6'd1, '1, "R3 all ones");
    rd(6'd1, 64'hFFFF_FFFF_FFFF_8000, "R3 low bits cleared");
    wr(6'd1, 64'h1_7FFF, "R3 pattern");
    rd(6'd1, 64'h1_0000, "R3 pattern cleared");

    // R5 level zero refusal
    bad(6'd16, 1'b0, "R5 banked read at level 0");
    bad(6'd16, 1'b1, "R5 banked write at level 0");

    // R4 banking
    wr(6'd2, 64'd1, "R4 level 1");
    rd(6'd16, 64'h0, "R5 refused write left state");
    wr(6'd16, 64'hAAAA_0001, "R4 tpc level 1");
    wr(6'd19, 64'h21, "R4 tt level 1");
    wr(6'd2, 64'd2, "R4 level 2");
    wr(6'd16, 64'hBBBB_0002, "R4 tpc level 2");
    wr(6'd19, 64'h42, "R4 tt level 2");
    rd(6'd16, 64'hBBBB_0002, "R4 tpc level 2 read");
    rd(6'd19, 64'h42, "R4 tt level 2 read");
    rd(6'd2, 64'd2, "R4 level readback");
    wr(6'd2, 64'd1, "R4 back to level 1");
    rd(6'd16, 64'hAAAA_0001, "R4 tpc level 1 read");
    rd(6'd19, 64'h21, "R4 tt level 1 read");
    rd(6'd20, 64'h0, "R4 htstate untouched");
    wr(6'd2, 64'd4, "R4 top level");
    wr(6'd20, 64'hCCCC_0004, "R4 htstate top level");
    rd(6'd20, 64'hCCCC_0004, "R4 htstate top read");

    // R5 above max
    wr(6'd2, 64'd5, "R5 level above max");
    bad(6'd17, 1'b0, "R5 read above max");
    bad(6'd20, 1'b1, "R5 write above max");
    wr(6'd2, 64'd4, "R5 return to top");
    rd(6'd20, 64'hCCCC_0004, "R5 refused write kept value");

    // R9 scratch and queue
    for (int i = 0; i < 8; i++) begin
      wr(6'(24 + i), 64'hA5A5_0000_0000_0000 | 64'(i * 32'h111), "R9 scratch write");
      wr(6'(32 + i), 64'h5A5A_0000_0000_0000 | 64'(i * 32'h203), "R9 queue write");
    end

    // R8 illegal indices
    bad(6'd63, 1'b0, "R8 read index 63");
    bad(6'd11, 1'b1, "R8 write index 11");
    bad(6'd21, 1'b0, "R8 gap after bank");
    bad(6'd40, 1'b1, "R8 write after queue");
    bad(6'd23, 1'b1, "R8 write before scratch");

    for (int i = 0; i < 8; i++) begin
      rd(6'(24 + i), 64'hA5A5_0000_0000_0000 | 64'(i * 32'h111), "R9 scratch read / R8 no change");
      rd(6'(32 + i), 64'h5A5A_0000_0000_0000 | 64'(i * 32'h203), "R9 queue read / R8 no change");
    end

    // R7 context word
    wr(6'd3, 64'h24, "R7 hyper-state fields");
    wr(6'd0, 64'h0C, "R7 proc-state fields");
    wr(6'd9, 64'h0C, "R7 lsu fields");
    wr(6'd6, 64'h1A5, "R7 partition");
    wr(6'd7, 64'hFFFF_1234, "R7 primary");
    wr(6'd8, 64'hBEEF, "R7 secondary");
    wr(6'd2, 64'd3, "R7 level 3");
    rd(6'd10, 64'hBEEF_1234_0003_A53F, "R7 context word");
    bad(6'd10, 1'b1, "R7 context write refused");
    rd(6'd10, 64'hBEEF_1234_0003_A53F, "R7 context unchanged");

    // R10 trap-level-zero request
    wr(6'd3, 64'h1, "R10 enable");
    modelIrq = 1'b1;
    wr(6'd2, 64'd0, "R10 raise at level 0");
    modelIrq = 1'b0;
    wr(6'd2, 64'd1, "R10 clear on nonzero");
    wr(6'd3, 64'h5, "R10 hyper-privileged set");
    wr(6'd2, 64'd0, "R10 blocked by hyper-privilege");
    wr(6'd3, 64'h1, "R10 enable again");
    modelIrq = 1'b1;
    wr(6'd2, 64'd0, "R10 raise again");
    rd(6'd4, 64'h50000, "R10 holds across other read");
    wr(6'd3, 64'h0, "R10 holds across hyper-state write");
    modelIrq = 1'b0;
    wr(6'd2, 64'd0, "R10 cleared with enable off");

    repeat (3) @(negedge clk);
    if (qRd.size() != 0) begin
      nFails++;
      $display("FAIL R11 pending results: %0d left, expected 0", qRd.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule